// File: doc/BRIEF.md
# Vector Length Control Register Unit

This block keeps the vector-length state of a scalar core that carries a vector extension. It holds four values: the ceiling on vector length, the active vector length, a source element offset and a destination element offset. Three control registers give access to them: one for the active length, one for the ceiling, and one packed word that carries all four values for fast save and restore across a context switch.

The access port is a single-cycle register port. The caller drives a select code, a write enable and write data. In the same cycle it takes the read data, which is the value the core puts in the destination register. The active length is always clamped to the ceiling, and the ceiling can only shrink until the next reset. A write to the active length returns the value that was actually kept. A write to the ceiling returns the ceiling it held before. In the packed word both lengths are stored minus one, so that a 6-bit field can express lengths 1 to 64. The instruction decoder subtracts one for immediate-form writes before it drives the port.

Top module: `vlen_csr_unit`

## Requirements
- R1: After synchronous reset the ceiling is 64, the active length is 1 and both offsets are 0, so a packed read returns 0x0000003F.
- R2: A write to the active-length register (select 1) stores the smaller of the write data and the current ceiling, comparing the full 32-bit value.
- R3: In the same cycle, a write to the active-length register returns the newly stored length on the read data, not the prior one.
- R4: A write to the ceiling register (select 2) returns the prior ceiling on the read data. The new ceiling is the smaller of the write data and the prior ceiling, so the ceiling never grows.
- R5: A read of select 1 or select 2 returns the true length (1 to 64), not the minus-one form.
- R6: The packed register (select 3) holds ceiling-1 in bits [5:0], active length-1 in bits [11:6], the source offset in bits [17:12] and the destination offset in bits [23:18].
- R7: A packed write first clamps the ceiling field plus one against the prior ceiling, then clamps the active field plus one against that new ceiling, and loads both offsets. The read data in that cycle is the packed word from before the write.
- R8: Bits [31:24] of the packed register read as zero and are ignored on write.
- R9: A write of zero to the active-length or ceiling register stores a length of 1.
- R10: With select 0 the read data is 0 and a write changes nothing. Any access with write enable low changes nothing.
- R11: The active length never exceeds the ceiling. A ceiling write that drops below the active length lowers the active length to the new ceiling in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_sel | input | 2 | Register select: 0 none, 1 active length, 2 ceiling, 3 packed state |
| csr_we | input | 1 | Write enable for the selected register |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data returned to the destination register (combinational) |

## Verification
Every piece of state is visible on the next access, because the packed register exposes all four values at once. A wrong ceiling or active length shows at the latest on the next packed or direct read, one cycle after the faulty write. A clamp that orders its steps wrongly, or that compares against the wrong ceiling, shows up when an oversized active-length field is written together with a smaller ceiling. The bench covers that case, along with zero writes, all-ones writes and ceiling shrinks that must pull the active length down.

// File: rtl/vlen_pkg.sv
package vlen_pkg;

    localparam int FIELD_W = 6;
    localparam int LEN_W   = FIELD_W + 1;
    localparam int MAX_LEN = 1 << FIELD_W;
    localparam int PACK_W  = 4 * FIELD_W;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_LEN   = 2'd1,
        SEL_CEIL  = 2'd2,
        SEL_PACK  = 2'd3
    } csr_sel_e;

    typedef struct packed {
        logic [LEN_W-1:0]   ceil;
        logic [LEN_W-1:0]   len;
        logic [FIELD_W-1:0] src_off;
        logic [FIELD_W-1:0] dst_off;
    } vstate_t;

    localparam vstate_t VSTATE_RESET = '{
        ceil:    LEN_W'(MAX_LEN),
        len:     LEN_W'(1),
        src_off: '0,
        dst_off: '0
    };

    function automatic logic [FIELD_W-1:0] to_minus_one(input logic [LEN_W-1:0] n);
        logic [LEN_W-1:0] t;
        t = n - LEN_W'(1);
        return t[FIELD_W-1:0];
    endfunction

    function automatic logic [LEN_W-1:0] from_minus_one(input logic [FIELD_W-1:0] f);
        return LEN_W'(f) + LEN_W'(1);
    endfunction

endpackage

// File: rtl/vlen_clamp.sv
module vlen_clamp #(
    parameter int IN_W  = 32,
    parameter int LEN_W = 7
) (
    input  logic [IN_W-1:0]  req,
    input  logic [LEN_W-1:0] limit,
    output logic [LEN_W-1:0] len
);
    logic [IN_W-1:0] limit_ext;

    assign limit_ext = IN_W'(limit);

    always_comb begin
        if (req == '0)
            len = LEN_W'(1);
        else if (req > limit_ext)
            len = limit;
        else
            len = req[LEN_W-1:0];
    end
endmodule

// File: rtl/vlen_state_codec.sv
module vlen_state_codec
    import vlen_pkg::*;
(
    input  vstate_t             st,
    output logic [PACK_W-1:0]   packed_word,
    input  logic [PACK_W-1:0]   in_word,
    output logic [LEN_W-1:0]    in_ceil,
    output logic [LEN_W-1:0]    in_len,
    output logic [FIELD_W-1:0]  in_src,
    output logic [FIELD_W-1:0]  in_dst
);
    assign packed_word = {st.dst_off, st.src_off,
                          to_minus_one(st.len), to_minus_one(st.ceil)};

    assign in_ceil = from_minus_one(in_word[FIELD_W-1:0]);
    assign in_len  = from_minus_one(in_word[2*FIELD_W-1:FIELD_W]);
    assign in_src  = in_word[3*FIELD_W-1:2*FIELD_W];
    assign in_dst  = in_word[4*FIELD_W-1:3*FIELD_W];
endmodule

// File: rtl/vlen_csr_unit.sv
module vlen_csr_unit
    import vlen_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      csr_sel,
    input  logic            csr_we,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata
);
    vstate_t            st_q, st_d;
    csr_sel_e           sel;
    logic [PACK_W-1:0]  pack_rd;
    logic [LEN_W-1:0]   wr_ceil, wr_len, direct_len, shrunk_len;
    logic [LEN_W-1:0]   pk_ceil_raw, pk_len_raw, pk_ceil, pk_len;
    logic [FIELD_W-1:0] pk_src, pk_dst;

    assign sel = csr_sel_e'(csr_sel);

    // direct write value clamped to the present ceiling
    vlen_clamp #(.IN_W(XLEN), .LEN_W(LEN_W)) u_clamp_direct (
        .req(csr_wdata), .limit(st_q.ceil), .len(direct_len)
    );

    // active length pulled under a shrinking ceiling
    vlen_clamp #(.IN_W(LEN_W), .LEN_W(LEN_W)) u_clamp_shrink (
        .req(st_q.len), .limit(direct_len), .len(shrunk_len)
    );

    vlen_state_codec u_codec (
        .st(st_q), .packed_word(pack_rd),
        .in_word(csr_wdata[PACK_W-1:0]),
        .in_ceil(pk_ceil_raw), .in_len(pk_len_raw),
        .in_src(pk_src), .in_dst(pk_dst)
    );

    // packed write: ceiling first, then length against the new ceiling
    vlen_clamp #(.IN_W(LEN_W), .LEN_W(LEN_W)) u_clamp_pk_ceil (
        .req(pk_ceil_raw), .limit(st_q.ceil), .len(pk_ceil)
    );
    vlen_clamp #(.IN_W(LEN_W), .LEN_W(LEN_W)) u_clamp_pk_len (
        .req(pk_len_raw), .limit(pk_ceil), .len(pk_len)
    );

    assign wr_ceil = direct_len;
    assign wr_len  = direct_len;

    always_comb begin
        st_d = st_q;
        if (csr_we) begin
            unique case (sel)
                SEL_LEN:  st_d.len = wr_len;
                SEL_CEIL: begin
                    st_d.ceil = wr_ceil;
                    st_d.len  = shrunk_len;
                end
                SEL_PACK: begin
                    st_d.ceil    = pk_ceil;
                    st_d.len     = pk_len;
                    st_d.src_off = pk_src;
                    st_d.dst_off = pk_dst;
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= VSTATE_RESET;
        else     st_q <= st_d;
    end

    always_comb begin
        unique case (sel)
            SEL_LEN:  csr_rdata = csr_we ? XLEN'(wr_len) : XLEN'(st_q.len);
            SEL_CEIL: csr_rdata = XLEN'(st_q.ceil);
            SEL_PACK: csr_rdata = XLEN'(pack_rd);
            default:  csr_rdata = '0;
        endcase
    end
endmodule

// File: rtl/vlen_csr_chk.sv
module vlen_csr_chk
    import vlen_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      csr_sel,
    input logic            csr_we,
    input logic [XLEN-1:0] csr_rdata,
    input logic [LEN_W-1:0] len,
    input logic [LEN_W-1:0] ceil
);
    a_r11_len_within_ceil: assert property (@(posedge clk) disable iff (rst)
        (len <= ceil) && (len != '0));

    a_r4_ceil_never_grows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ceil <= $past(ceil));

    a_r3_len_write_echo: assert property (@(posedge clk) disable iff (rst)
        (csr_sel == 2'd1 && csr_we) |=> XLEN'(len) == $past(csr_rdata));

    a_r4_ceil_write_returns_old: assert property (@(posedge clk) disable iff (rst)
        (csr_sel == 2'd2 && csr_we) |=> XLEN'(ceil) <= $past(csr_rdata));

    a_r10_no_write_no_change: assert property (@(posedge clk) disable iff (rst)
        (!csr_we || csr_sel == 2'd0) |=> ($stable(len) && $stable(ceil)));

    a_r8_top_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (csr_sel == 2'd3) |-> csr_rdata[XLEN-1:PACK_W] == '0);
endmodule

bind vlen_csr_unit vlen_csr_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst(rst), .csr_sel(csr_sel), .csr_we(csr_we),
    .csr_rdata(csr_rdata), .len(st_q.len), .ceil(st_q.ceil)
);

// File: tb/vlen_csr_unit_test.sv
module vlen_csr_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  csr_sel = 2'd0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    vlen_csr_unit uut (
        .clk(clk), .rst(rst), .csr_sel(csr_sel), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
    );

    // row: {sel[1:0], we, wdata[31:0], expected rdata[31:0], requirement[7:0]}
    localparam int NV = 24;
    localparam logic [74:0] VEC [NV] = '{
        {2'd3, 1'b0, 32'h0,        32'h3F,     8'd1},  // R1 packed reset
        {2'd1, 1'b0, 32'h0,        32'd1,      8'd1},  // R1 length
        {2'd2, 1'b0, 32'h0,        32'd64,     8'd5},  // R5 ceiling true value
        {2'd1, 1'b1, 32'd10,       32'd10,     8'd3},  // R3 new value echoed
        {2'd1, 1'b0, 32'h0,        32'd10,     8'd2},  // R2 stored
        {2'd1, 1'b1, 32'd0,        32'd1,      8'd9},  // R9 zero -> 1
        {2'd1, 1'b0, 32'h0,        32'd1,      8'd9},
        {2'd1, 1'b1, 32'd100,      32'd64,     8'd2},  // R2 clamp
        {2'd3, 1'b0, 32'h0,        32'hFFF,    8'd6},  // R6 layout
        {2'd2, 1'b1, 32'd40,       32'd64,     8'd4},  // R4 returns old
        {2'd2, 1'b0, 32'h0,        32'd40,     8'd4},
        {2'd1, 1'b0, 32'h0,        32'd40,     8'd11}, // R11 length pulled down
        {2'd2, 1'b1, 32'd50,       32'd40,     8'd4},  // R4 no growth
        {2'd2, 1'b0, 32'h0,        32'd40,     8'd4},
        {2'd3, 1'b1, 32'hFF2459DF, 32'h9E7,    8'd7},  // R7 returns prior word
        {2'd3, 1'b0, 32'h0,        32'h2457DF, 8'd8},  // R8 top byte dropped
        {2'd1, 1'b0, 32'h0,        32'd32,     8'd7},  // R7 length vs new ceiling
        {2'd2, 1'b0, 32'h0,        32'd32,     8'd7},
        {2'd0, 1'b1, 32'h123,      32'd0,      8'd10}, // R10 no select
        {2'd3, 1'b0, 32'h0,        32'h2457DF, 8'd10},
        {2'd1, 1'b1, 32'hFFFFFFFF, 32'd32,     8'd2},  // R2 full-width compare
        {2'd2, 1'b1, 32'd0,        32'd32,     8'd9},  // R9 ceiling zero
        {2'd2, 1'b0, 32'h0,        32'd1,      8'd9},
        {2'd1, 1'b0, 32'h0,        32'd1,      8'd11}  // R11
    };

    task automatic check(input logic [31:0] exp, input int req, input string what);
        n_chk++;
        if (csr_rdata !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: got 0x%08h expected 0x%08h", req, what, csr_rdata, exp);
        end
    endtask

    task automatic access(input logic [1:0] s, input logic w, input logic [31:0] d,
                          input logic [31:0] exp, input int req, input string what);
        @(negedge clk);
        csr_sel = s; csr_we = w; csr_wdata = d;
        #5;
        check(exp, req, what);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][74:73], VEC[i][72], VEC[i][71:40], VEC[i][39:8],
                   int'(VEC[i][7:0]), $sformatf("vector %0d", i));
        end
        // R1: reset mid-run restores initial state
        @(negedge clk);
        csr_sel = 2'd0; csr_we = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        access(2'd3, 1'b0, 32'h0, 32'h3F, 1, "reset again");
        // R7/R6: max ceiling field, min length field, max offsets
        access(2'd3, 1'b1, 32'h00FFF03F, 32'h3F, 7, "packed write");
        access(2'd3, 1'b0, 32'h0, 32'hFFF03F, 6, "packed readback");
        access(2'd2, 1'b0, 32'h0, 32'd64, 5, "ceiling after packed");
        access(2'd1, 1'b0, 32'h0, 32'd1, 5, "length after packed");
        @(negedge clk);
        csr_sel = 2'd0; csr_we = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule